// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Collector

This block gathers up to 64 level-sensitive interrupt request lines and presents one interrupt request to a processor. Each source has a 2-bit priority, an enable and a software-force bit. Among the sources that are pending and allowed by the current in-service state, the block picks one winner. The CPU IRQ output is a registered copy of "a winner exists and interrupts are globally enabled".

Software reads a vector address, formed from a programmable table base plus four times the winning source number, and jumps through it. Taking an interrupt marks its priority level as in service. A control bit selects whether that happens on a write to the vector register or as a side effect of reading it. While a level is in service, only strictly higher levels can interrupt. With nesting disabled, nothing can interrupt. Software ends a level by writing a one to that level's bit in the acknowledge register.

Every register sits on a 32-bit register bus. Address bits [3:2] select one of four aliases: plain write, bitwise set, clear-on-one or toggle-on-one. Read data is registered and valid one cycle after the read strobe.

Top module: `prio_irq_collector`

## Requirements
- R1: After a synchronous reset, every stored register, the in-service levels, `bus_rdata` and `cpu_irq` are zero.
- R2: For a writable register at base address A, a write to A+0x0 stores the data. A write to A+0x4 ORs the data in, A+0x8 clears the bits written as one, and A+0xC inverts the bits written as one. A read at any alias returns the register one cycle after `bus_rd`.
- R3: Control words for the sources start at 0x060 and are spaced 0x10 apart. Source n lives in word n/4 at bits [8*(n%4)+7 : 8*(n%4)]. Within a source's byte, [1:0] is the priority, [2] is the enable and [3] is the software force. All 32 bits read back as written.
- R4: A source is pending when its enable bit is set and either its line or its force bit is high. Register 0x040 reads lines 0–31 and 0x050 reads lines 32–63, unmasked, without the force bits.
- R5: Among eligible sources, the higher priority wins, and on equal priority the lower source number wins.
- R6: The table base at 0x160 stores bits [31:2] and reads bits [1:0] as zero. The vector register at 0x000 reads as base + 4 × winner, or as the base alone when there is no winner.
- R7: With control bit 1 (0x020) clear, a write to the vector register puts the winner's level in service and a read does not. With bit 1 set, a read does so and a write does not. Nothing happens when there is no winner.
- R8: The status register at 0x030 holds in bits [5:0] the source number latched at the last in-service event, and is unchanged otherwise.
- R9: With nesting enabled, a source is eligible only if its priority is strictly greater than the highest level in service.
- R10: When control bit 2 (no nesting) is set and any level is in service, `cpu_irq` is low.
- R11: Writing a one to bit k of 0x010, at any alias, ends service at level k. Reading 0x010 returns the in-service levels in bits [3:0].
- R12: `cpu_irq` is high in the cycle after a winner exists while control bit 0 (global enable) is set, and low otherwise.
- R13: Register 0x170 is a plain 32-bit scratch register with no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NSRC | Level interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address; bits [3:2] select the alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The arbiter is tried with a single pending source, a tie at equal priority, a demoted source, and a higher level forced by software. These patterns separate the priority compare from the source-number tie-break, and show that the force bit feeds the arbiter but not the raw view. In-service entry is driven by vector writes and by vector reads under both settings of the mode bit, which shows that each mode ignores the other strobe. Nesting is tested with a lower level in service against equal and higher pending levels, with the no-nesting bit both set and clear. A behavioural model compared on every clock also covers the alias arithmetic on each writable register.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PW   = 2;
  localparam int NLVL = 1 << PW;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TOG = 2'd3
  } alias_op_t;

  function automatic logic [31:0] alias_apply(input logic [31:0] cur,
                                              input logic [31:0] wd,
                                              input alias_op_t   op);
    case (op)
      OP_WR:   return wd;
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      default: return cur ^ wd;
    endcase
  endfunction
endpackage

// File: rtl/pic_src_bank.sv
module pic_src_bank
  import pic_pkg::*;
#(
  parameter  int NSRC  = 64,
  localparam int PER   = 4,
  localparam int NWORD = NSRC / PER,
  localparam int IW    = $clog2(NWORD)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [IW-1:0]         widx,
  input  alias_op_t             wop,
  input  logic [31:0]           wdata,
  input  logic [NSRC-1:0]       lines,
  output logic [NWORD*32-1:0]   words_flat,
  output logic [NSRC-1:0]       pend,
  output logic [PW*NSRC-1:0]    prio_flat
);
  logic [31:0] cw [NWORD];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NWORD; k++) cw[k] <= '0;
    end else if (we) begin
      cw[widx] <= alias_apply(cw[widx], wdata, wop);
    end
  end

  for (genvar k = 0; k < NWORD; k++) begin : g_word
    assign words_flat[k*32 +: 32] = cw[k];
  end

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    localparam int WI = n / PER;
    localparam int BO = 8 * (n % PER);
    assign prio_flat[n*PW +: PW] = cw[WI][BO +: PW];
    assign pend[n] = cw[WI][BO+2] & (lines[n] | cw[WI][BO+3]);
  end
endmodule

// File: rtl/pic_arb.sv
module pic_arb
  import pic_pkg::*;
#(
  parameter  int NSRC = 64,
  localparam int NW   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]     pend,
  input  logic [PW*NSRC-1:0]  prio_flat,
  input  logic [PW:0]         min_lvl,
  output logic                found,
  output logic [NW-1:0]       num,
  output logic [PW-1:0]       lvl
);
  always_comb begin
    logic [PW-1:0] p;
    found = 1'b0;
    num   = '0;
    lvl   = '0;
    for (int i = 0; i < NSRC; i++) begin
      p = prio_flat[i*PW +: PW];
      if (pend[i] && ({1'b0, p} >= min_lvl) && (!found || p > lvl)) begin
        found = 1'b1;
        num   = NW'(i);
        lvl   = p;
      end
    end
  end
endmodule

// File: rtl/pic_lvl_track.sv
module pic_lvl_track
  import pic_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            set_evt,
  input  logic [PW-1:0]   set_lvl,
  input  logic [NLVL-1:0] ack_mask,
  output logic [NLVL-1:0] in_svc,
  output logic            any_svc,
  output logic [PW:0]     floor_lvl
);
  logic [NLVL-1:0] nxt;

  always_comb begin
    nxt = in_svc & ~ack_mask;
    if (set_evt) nxt[set_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) in_svc <= '0;
    else     in_svc <= nxt;
  end

  always_comb begin
    floor_lvl = '0;
    for (int l = 0; l < NLVL; l++)
      if (in_svc[l]) floor_lvl = (PW+1)'(l + 1);
  end

  assign any_svc = |in_svc;
endmodule

// File: rtl/prio_irq_collector.sv
module prio_irq_collector
  import pic_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int AW   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  irq_lines,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             cpu_irq
);
  localparam int NWORD = NSRC / 4;
  localparam int IW    = $clog2(NWORD);
  localparam int NW    = $clog2(NSRC);
  localparam int XW    = AW - 4;
  localparam logic [XW-1:0] IX_VEC   = XW'(0);
  localparam logic [XW-1:0] IX_ACK   = XW'(1);
  localparam logic [XW-1:0] IX_CTRL  = XW'(2);
  localparam logic [XW-1:0] IX_STAT  = XW'(3);
  localparam logic [XW-1:0] IX_RAW0  = XW'(4);
  localparam logic [XW-1:0] IX_RAW1  = XW'(5);
  localparam logic [XW-1:0] IX_CW0   = XW'(6);
  localparam logic [XW-1:0] IX_CWE   = XW'(6 + NWORD);
  localparam logic [XW-1:0] IX_VBASE = XW'(6 + NWORD);
  localparam logic [XW-1:0] IX_SCR   = XW'(7 + NWORD);

  logic [XW-1:0]       idx;
  alias_op_t           op;
  logic                cw_hit;
  logic [IW-1:0]       cw_sel;
  logic [NWORD*32-1:0] cw_words;
  logic [NSRC-1:0]     pend;
  logic [PW*NSRC-1:0]  prio_flat;
  logic [2:0]          ctrl_q;
  logic [31:0]         vbase_q, scr_q, ctrl_nx, vbase_nx, vec_val, rd_mux;
  logic [NW-1:0]       status_q, win_num;
  logic [PW-1:0]       win_lvl;
  logic                win_found, svc_evt, any_svc;
  logic [NLVL-1:0]     in_svc, ack_mask;
  logic [PW:0]         svc_floor, min_lvl;
  logic [63:0]         raw_ext;

  assign idx     = bus_addr[AW-1:4];
  assign op      = alias_op_t'(bus_addr[3:2]);
  assign cw_hit  = (idx >= IX_CW0) && (idx < IX_CWE);
  assign cw_sel  = IW'(idx - IX_CW0);
  assign raw_ext = 64'(irq_lines);

  pic_src_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst(rst), .we(bus_wr && cw_hit), .widx(cw_sel), .wop(op),
    .wdata(bus_wdata), .lines(irq_lines), .words_flat(cw_words),
    .pend(pend), .prio_flat(prio_flat)
  );

  assign min_lvl = (ctrl_q[2] && any_svc) ? (PW+1)'(NLVL) : svc_floor;

  pic_arb #(.NSRC(NSRC)) u_arb (
    .pend(pend), .prio_flat(prio_flat), .min_lvl(min_lvl),
    .found(win_found), .num(win_num), .lvl(win_lvl)
  );

  assign svc_evt  = win_found && (idx == IX_VEC) && (ctrl_q[1] ? bus_rd : bus_wr);
  assign ack_mask = (bus_wr && idx == IX_ACK) ? bus_wdata[NLVL-1:0] : '0;

  pic_lvl_track u_lvl (
    .clk(clk), .rst(rst), .set_evt(svc_evt), .set_lvl(win_lvl),
    .ack_mask(ack_mask), .in_svc(in_svc), .any_svc(any_svc),
    .floor_lvl(svc_floor)
  );

  assign ctrl_nx  = alias_apply({29'b0, ctrl_q}, bus_wdata, op);
  assign vbase_nx = alias_apply(vbase_q, bus_wdata, op) & 32'hFFFF_FFFC;
  assign vec_val  = vbase_q + (32'(win_num) << 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      vbase_q  <= '0;
      scr_q    <= '0;
      status_q <= '0;
    end else begin
      if (bus_wr && idx == IX_CTRL)  ctrl_q  <= ctrl_nx[2:0];
      if (bus_wr && idx == IX_VBASE) vbase_q <= vbase_nx;
      if (bus_wr && idx == IX_SCR)   scr_q   <= alias_apply(scr_q, bus_wdata, op);
      if (svc_evt)                   status_q <= win_num;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (cw_hit) begin
      rd_mux = cw_words[cw_sel*32 +: 32];
    end else begin
      case (idx)
        IX_VEC:   rd_mux = vec_val;
        IX_ACK:   rd_mux = 32'(in_svc);
        IX_CTRL:  rd_mux = 32'(ctrl_q);
        IX_STAT:  rd_mux = 32'(status_q);
        IX_RAW0:  rd_mux = raw_ext[31:0];
        IX_RAW1:  rd_mux = raw_ext[63:32];
        IX_VBASE: rd_mux = vbase_q;
        IX_SCR:   rd_mux = scr_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      cpu_irq <= ctrl_q[0] & win_found;
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_irq,
  input logic [2:0] ctrl_q,
  input logic [3:0] in_svc,
  input logic [3:0] ack_mask,
  input logic       svc_evt,
  input logic [5:0] status_q,
  input logic [1:0] win_lvl,
  input logic [2:0] svc_floor
);
  // R12
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[0] |=> !cpu_irq);

  // R10
  no_nest_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[2] && (in_svc != 4'b0)) |=> !cpu_irq);

  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((ack_mask != 4'b0) && !svc_evt) |=> ((in_svc & $past(ack_mask)) == 4'b0));

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !svc_evt |=> $stable(status_q));

  // R7
  svc_mark_chk: assert property (@(posedge clk) disable iff (rst)
    svc_evt |=> in_svc[$past(win_lvl)]);

  // R9
  nest_level_chk: assert property (@(posedge clk) disable iff (rst)
    svc_evt |-> ({1'b0, win_lvl} >= svc_floor));
endmodule

bind prio_irq_collector pic_chk u_chk (
  .clk(clk), .rst(rst), .cpu_irq(cpu_irq), .ctrl_q(ctrl_q),
  .in_svc(in_svc), .ack_mask(ack_mask), .svc_evt(svc_evt),
  .status_q(status_q), .win_lvl(win_lvl), .svc_floor(svc_floor)
);

// File: tb/prio_irq_collector_test.sv
module prio_irq_collector_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_lines = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;

  always #10 clk = ~clk;

  prio_irq_collector uut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // behavioural reference model
  logic [31:0] m_cw [16];
  logic [31:0] m_vb, m_scr, m_rd;
  logic [2:0]  m_ctrl;
  logic [3:0]  m_svc;
  logic [5:0]  m_stat;
  logic        m_irq;

  function automatic logic [31:0] ap(input logic [31:0] c, input logic [31:0] d, input logic [1:0] o);
    if (o == 2'd0) return d;
    if (o == 2'd1) return c | d;
    if (o == 2'd2) return c & ~d;
    return c ^ d;
  endfunction

  always @(posedge clk) begin : mdl
    int top, wn, wl, pr;
    bit any, fnd, svc;
    logic [7:0] f, ix;
    logic [31:0] nv;
    if (rst) begin
      for (int k = 0; k < 16; k++) m_cw[k] = '0;
      m_vb = '0; m_scr = '0; m_rd = '0; m_ctrl = '0; m_svc = '0; m_stat = '0; m_irq = 1'b0;
    end else begin
      any = 0; top = -1;
      for (int l = 0; l < 4; l++) if (m_svc[l]) begin any = 1; top = l; end
      fnd = 0; wn = 0; wl = 0;
      for (int n = 0; n < 64; n++) begin
        f  = 8'(m_cw[n/4] >> (8*(n%4)));
        pr = int'(f[1:0]);
        if (f[2] && (irq_lines[n] || f[3]) && (!any || (!m_ctrl[2] && pr > top))
            && (!fnd || pr > wl)) begin
          fnd = 1; wn = n; wl = pr;
        end
      end
      m_irq = m_ctrl[0] & fnd;
      ix = bus_addr[11:4];
      if (bus_rd) begin
        if (ix == 0)                m_rd = m_vb + 32'(wn * 4);
        else if (ix == 1)           m_rd = {28'b0, m_svc};
        else if (ix == 2)           m_rd = {29'b0, m_ctrl};
        else if (ix == 3)           m_rd = {26'b0, m_stat};
        else if (ix == 4)           m_rd = irq_lines[31:0];
        else if (ix == 5)           m_rd = irq_lines[63:32];
        else if (ix >= 6 && ix < 22) m_rd = m_cw[ix-6];
        else if (ix == 22)          m_rd = m_vb;
        else if (ix == 23)          m_rd = m_scr;
        else                        m_rd = '0;
      end
      svc = fnd && (ix == 0) && (m_ctrl[1] ? bus_rd : bus_wr);
      if (bus_wr) begin
        if (ix == 1) m_svc = m_svc & ~bus_wdata[3:0];
        else if (ix == 2) begin nv = ap({29'b0, m_ctrl}, bus_wdata, bus_addr[3:2]); m_ctrl = nv[2:0]; end
        else if (ix >= 6 && ix < 22) m_cw[ix-6] = ap(m_cw[ix-6], bus_wdata, bus_addr[3:2]);
        else if (ix == 22) m_vb = ap(m_vb, bus_wdata, bus_addr[3:2]) & 32'hFFFF_FFFC;
        else if (ix == 23) m_scr = ap(m_scr, bus_wdata, bus_addr[3:2]);
      end
      if (svc) begin m_svc[wl] = 1'b1; m_stat = 6'(wn); end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R12 cpu_irq vs model", {31'b0, cpu_irq}, {31'b0, m_irq});
      chk("R2 rdata vs model", bus_rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      finish_up();
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    repeat (2) @(negedge clk);
    chk(tag, {31'b0, cpu_irq}, {31'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk("R1 cpu_irq after reset", {31'b0, cpu_irq}, 32'h0);
    rd_chk(12'h020, 32'h0, "R1 ctrl reset");
    rd_chk(12'h170, 32'h0, "R1 scratch reset");
    rd_chk(12'h160, 32'h0, "R1 vbase reset");
    rd_chk(12'h010, 32'h0, "R1 in-service reset");
    // aliases on scratch
    wr(12'h170, 32'hA5A5_0F0F); rd_chk(12'h170, 32'hA5A5_0F0F, "R13 scratch plain");
    wr(12'h174, 32'h0000_F000); rd_chk(12'h174, 32'hA5A5_FF0F, "R2 set alias");
    wr(12'h178, 32'hA5A5_0000); rd_chk(12'h178, 32'h0000_FF0F, "R2 clear alias");
    wr(12'h17C, 32'hFFFF_0000); rd_chk(12'h170, 32'hFFFF_FF0F, "R2 toggle alias");
    wr(12'h020, 32'hFFFF_FFFF); rd_chk(12'h020, 32'h7, "R2 ctrl width");
    wr(12'h028, 32'h6);         rd_chk(12'h020, 32'h1, "R2 ctrl clear");
    wr(12'h160, 32'h8000_0003); rd_chk(12'h160, 32'h8000_0000, "R6 base low bits");
    // single source 5, priority 2
    wr(12'h070, 32'h0000_0600);
    irq_lines[5] = 1'b1;
    rd_chk(12'h040, 32'h0000_0020, "R4 raw low");
    rd_chk(12'h050, 32'h0, "R4 raw high");
    irq_chk(1'b1, "R4 pending raises irq");
    rd_chk(12'h000, 32'h8000_0014, "R6 vector src5");
    rd_chk(12'h010, 32'h0, "R7 read ignored in write mode");
    wr(12'h028, 32'h1); irq_chk(1'b0, "R12 global enable off");
    wr(12'h024, 32'h1); irq_chk(1'b1, "R12 global enable on");
    // source 9 disabled then tie
    wr(12'h080, 32'h0000_0200);
    irq_lines[9] = 1'b1;
    rd_chk(12'h040, 32'h0000_0220, "R4 raw two lines");
    rd_chk(12'h000, 32'h8000_0014, "R4 disabled source ignored");
    wr(12'h084, 32'h0000_0400);
    rd_chk(12'h080, 32'h0000_0600, "R3 word readback");
    rd_chk(12'h000, 32'h8000_0014, "R5 tie lower number");
    wr(12'h070, 32'h0000_0500);
    rd_chk(12'h000, 32'h8000_0024, "R5 higher priority src9");
    wr(12'h070, 32'h0000_0600);
    // source 40 forced at priority 3
    wr(12'h100, 32'h0000_000F);
    rd_chk(12'h100, 32'h0000_000F, "R3 word10 byte0");
    rd_chk(12'h050, 32'h0, "R4 force not in raw");
    rd_chk(12'h000, 32'h8000_00A0, "R5 forced priority 3 wins");
    // in service by write
    wr(12'h000, 32'h0);
    rd_chk(12'h030, 32'h0000_0028, "R8 status 40");
    rd_chk(12'h010, 32'h0000_0008, "R7 write marks level 3");
    irq_chk(1'b0, "R9 nothing above level 3");
    wr(12'h01C, 32'h8);
    rd_chk(12'h010, 32'h0, "R11 ack via toggle alias");
    irq_chk(1'b1, "R11 irq returns after ack");
    // nesting
    wr(12'h108, 32'h0000_0008);
    wr(12'h000, 32'h0);
    rd_chk(12'h030, 32'h0000_0005, "R8 status 5");
    rd_chk(12'h010, 32'h0000_0004, "R7 level 2 in service");
    irq_chk(1'b0, "R9 equal level blocked");
    wr(12'h104, 32'h0000_0008);
    irq_chk(1'b1, "R9 higher level nests");
    wr(12'h024, 32'h2);
    wr(12'h000, 32'h0);
    rd_chk(12'h010, 32'h0000_0004, "R7 write ignored in read mode");
    rd_chk(12'h000, 32'h8000_00A0, "R7 read mode vector");
    rd_chk(12'h030, 32'h0000_0028, "R8 status after read svc");
    rd_chk(12'h010, 32'h0000_000C, "R7 read marks level 3");
    // no nesting
    wr(12'h010, 32'hF);
    rd_chk(12'h010, 32'h0, "R11 ack all");
    wr(12'h108, 32'h0000_0004);
    rd_chk(12'h000, 32'h8000_0014, "R7 read takes src5");
    rd_chk(12'h010, 32'h0000_0004, "R7 level 2 via read");
    wr(12'h024, 32'h4);
    wr(12'h104, 32'h0000_0004);
    irq_chk(1'b0, "R10 no nesting holds irq low");
    wr(12'h028, 32'h4);
    irq_chk(1'b1, "R10 nesting restored");
    rd_chk(12'h030, 32'h0000_0005, "R8 status held");
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule